// File: doc/BRIEF.md
# Cache-Block Zero Engine

This block carries out a cache-block zero request for a processor core. A request brings an effective address, the current privilege level, a flag for virtualized execution and three enable bits. The enable bits come from the machine, hypervisor and supervisor environment-configuration registers. The engine first decides whether the request is allowed. If it is not, it reports either an illegal-instruction exception or a virtual-instruction exception. If it is allowed, it clears the low address bits to reach the start of the block. It then writes a zero byte to every address in the block through a byte-wide memory write port, and pulses a completion flag.

Requests arrive on a valid/ready pair. `req_ready` is high only while the engine is idle. A request is taken on a cycle where both `req_valid` and `req_ready` are high. The write port also uses valid/ready. Once `wr_valid` is raised it stays high, with the same address and data, until the sink raises `wr_ready`. A write counts as done only on a cycle where both are high. On such a cycle the sink may raise `wr_fault` to reject the store. This ends the sequence, and bytes already written stay written. The cache-block size is the parameter `BLK_BYTES`, a power of two of at least 2, with a default of 64.

Top module: `cbz_engine`

## Requirements
- R1: After reset the engine is idle: `req_ready` is 1, and `wr_valid`, `done` and `exc_valid` are 0.
- R2: When privilege is below machine level (privilege code 0 = user, 1 = supervisor, 3 = machine) and the machine enable is 0, the request ends with `exc_kind` = 1 (illegal instruction) and no write is issued.
- R3: If the machine check passes and the virtualization flag is set, `exc_kind` = 2 (virtual instruction) is reported when either of two cases holds. The first is privilege user or supervisor with the hypervisor enable at 0. The second is privilege user with the supervisor enable at 0.
- R4: If both earlier checks pass, a user-level request with the supervisor enable at 0 ends with `exc_kind` = 1.
- R5: The checks run in a fixed order: machine, then virtual, then supervisor, and the first failure decides the kind. A machine-level request is never refused.
- R6: An allowed request writes the data byte 0 to every address of its block in ascending order. The first address is the request address with its low log2(`BLK_BYTES`) bits cleared.
- R7: With `wr_ready` held high, the writes fill exactly `BLK_BYTES` consecutive cycles, starting the cycle after the request is accepted. `done` pulses in the cycle after the last write is accepted.
- R8: While `wr_ready` is 0, `wr_valid` stays high and `wr_addr` and `wr_data` hold their values. The address moves on only after an accepted write.
- R9: An accepted write with `wr_fault` = 1 ends the sequence with no further writes. The next cycle carries `exc_kind` = 3 (store fault).
- R10: `done` and `exc_valid` each last one cycle and are never high together. For every exception, `exc_addr` holds the block-aligned request address.
- R11: A request is accepted only while idle. `req_valid` raised during a sequence changes neither its addresses nor its outcome, and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | AW | Effective address of the request |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Virtualized execution active |
| req_men | input | 1 | Machine-level zero enable |
| req_hen | input | 1 | Hypervisor-level zero enable |
| req_sen | input | 1 | Supervisor-level zero enable |
| wr_valid | output | 1 | Byte write offered |
| wr_ready | input | 1 | Sink accepts the write |
| wr_addr | output | AW | Byte address of the write |
| wr_data | output | 8 | Write data, always zero |
| wr_fault | input | 1 | Accepted write was rejected by the sink |
| done | output | 1 | One-cycle pulse: block fully zeroed |
| exc_valid | output | 1 | One-cycle pulse: request ended in an exception |
| exc_kind | output | 2 | 1 illegal, 2 virtual, 3 store fault |
| exc_addr | output | AW | Block-aligned address of the request |

## Verification
On every cycle the assertions check the handshake rules of the write port: the address and the zero data are held under back-pressure, and the address steps by one after each accepted write. They also check the outcome pulses: a fault handshake is followed by a store-fault report, a clean last write by `done`, and `done` and `exc_valid` stay one cycle long and never overlap. Only the bench's scenarios can show that the three-level enable check picks the right exception kind for each mix of privilege, virtualization and enable bits. The scenarios also cover that the block is complete and starts at the aligned address, and that a request offered mid-sequence is ignored.

// File: rtl/cbz_pkg.sv
package cbz_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_ILLEGAL = 2'd1,
    EXC_VIRTUAL = 2'd2,
    EXC_STFAULT = 2'd3
  } cbz_exc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ZERO = 2'd1,
    ST_RESP = 2'd2
  } cbz_state_e;
endpackage

// File: rtl/cbz_perm_check.sv
module cbz_perm_check
  import cbz_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       m_en,
  input  logic       h_en,
  input  logic       s_en,
  output cbz_exc_e   verdict
);
  logic below_m;
  logic is_user;
  logic user_or_sup;
  logic m_fail;
  logic v_fail;
  logic s_fail;

  assign below_m     = (priv != PRIV_M);
  assign is_user     = (priv == PRIV_U);
  assign user_or_sup = (priv == PRIV_U) || (priv == PRIV_S);

  assign m_fail = below_m && !m_en;
  assign v_fail = virt && ((user_or_sup && !h_en) || (is_user && !s_en));
  assign s_fail = is_user && !s_en;

  // Priority: machine, virtual, supervisor
  always_comb begin
    if (m_fail)      verdict = EXC_ILLEGAL;
    else if (v_fail) verdict = EXC_VIRTUAL;
    else if (s_fail) verdict = EXC_ILLEGAL;
    else             verdict = EXC_NONE;
  end
endmodule

// File: rtl/cbz_byte_walker.sv
module cbz_byte_walker #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic [AW-1:0] base_addr,
  output logic [AW-1:0] cur_addr,
  output logic          at_last
);
  localparam int OFS_W = $clog2(BLK_BYTES);

  logic [AW-1:OFS_W] base_hi;
  logic [OFS_W-1:0]  idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= '0;
      idx     <= '0;
    end else if (load) begin
      base_hi <= load_addr[AW-1:OFS_W];
      idx     <= '0;
    end else if (step) begin
      idx <= idx + OFS_W'(1);
    end
  end

  assign base_addr = {base_hi, {OFS_W{1'b0}}};
  assign cur_addr  = {base_hi, idx};
  assign at_last   = &idx;
endmodule

// File: rtl/cbz_engine.sv
module cbz_engine
  import cbz_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_priv,
  input  logic          req_virt,
  input  logic          req_men,
  input  logic          req_hen,
  input  logic          req_sen,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  input  logic          wr_fault,
  output logic          done,
  output logic          exc_valid,
  output logic [1:0]    exc_kind,
  output logic [AW-1:0] exc_addr
);
  cbz_state_e state_q;
  cbz_exc_e   resp_q;
  cbz_exc_e   verdict;
  logic       accept;
  logic       wr_fire;
  logic       step;
  logic       at_last;
  logic [AW-1:0] base_addr;
  logic [AW-1:0] cur_addr;

  assign accept  = req_valid && req_ready;
  assign wr_fire = wr_valid && wr_ready;
  assign step    = wr_fire && !wr_fault;

  cbz_perm_check u_perm (
    .priv    (req_priv),
    .virt    (req_virt),
    .m_en    (req_men),
    .h_en    (req_hen),
    .s_en    (req_sen),
    .verdict (verdict)
  );

  cbz_byte_walker #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (req_addr),
    .step      (step),
    .base_addr (base_addr),
    .cur_addr  (cur_addr),
    .at_last   (at_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      resp_q  <= EXC_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (verdict == EXC_NONE) begin
            state_q <= ST_ZERO;
          end else begin
            state_q <= ST_RESP;
            resp_q  <= verdict;
          end
        end
        ST_ZERO: if (wr_fire) begin
          if (wr_fault) begin
            state_q <= ST_RESP;
            resp_q  <= EXC_STFAULT;
          end else if (at_last) begin
            state_q <= ST_RESP;
            resp_q  <= EXC_NONE;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign wr_valid  = (state_q == ST_ZERO);
  assign wr_addr   = cur_addr;
  assign wr_data   = 8'h00;
  assign done      = (state_q == ST_RESP) && (resp_q == EXC_NONE);
  assign exc_valid = (state_q == ST_RESP) && (resp_q != EXC_NONE);
  assign exc_kind  = exc_valid ? resp_q : EXC_NONE;
  assign exc_addr  = base_addr;
endmodule

// File: rtl/cbz_engine_chk.sv
module cbz_engine_chk #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          wr_fault,
  input logic          done,
  input logic          exc_valid,
  input logic [1:0]    exc_kind,
  input logic [AW-1:0] exc_addr
);
  localparam int OFS_W = $clog2(BLK_BYTES);

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R6
  zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data == 8'h00);

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !wr_fault && (wr_addr[OFS_W-1:0] != {OFS_W{1'b1}})
    |=> wr_valid && (wr_addr == $past(wr_addr) + AW'(1)));

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !wr_fault && (wr_addr[OFS_W-1:0] == {OFS_W{1'b1}})
    |=> done && !wr_valid);

  // R9
  fault_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_fault |=> exc_valid && exc_kind == 2'd3 && !wr_valid);

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && exc_valid));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid);

  // R10
  exc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> exc_addr[OFS_W-1:0] == '0);

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !req_ready);

  // R11
  start_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(req_valid && req_ready));
endmodule

bind cbz_engine cbz_engine_chk #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_fault  (wr_fault),
  .done      (done),
  .exc_valid (exc_valid),
  .exc_kind  (exc_kind),
  .exc_addr  (exc_addr)
);

// File: tb/test_cbz_engine.sv
`timescale 1ns/1ps
module test_cbz_engine;
  localparam int AW  = 32;
  localparam int BLK = 64;
  localparam logic [AW-1:0] MASK = ~AW'(BLK - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_priv = 2'd3;
  logic          req_virt = 1'b0;
  logic          req_men = 1'b0;
  logic          req_hen = 1'b0;
  logic          req_sen = 1'b0;
  logic          wr_valid;
  logic          wr_ready = 1'b1;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          wr_fault = 1'b0;
  logic          done;
  logic          exc_valid;
  logic [1:0]    exc_kind;
  logic [AW-1:0] exc_addr;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cbz_engine #(.AW(AW), .BLK_BYTES(BLK)) i_cbz_engine (.*);

  // {priv[1:0], virt, men, hen, sen, kind[1:0]}
  localparam logic [7:0] VEC [12] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},  // R5 machine never refused
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},  // R5
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1},  // R2
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},  // R5 machine check first
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},  // R4 not for supervisor
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2},  // R3 hyp enable
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},  // R3 sup enable ignored at S
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2},  // R3 user, sup enable
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2},  // R3 user, hyp enable
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},  // R4
    {2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0},  // R6
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0}   // R6
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drives a request; returns at the negedge one cycle after acceptance.
  task automatic do_req(input logic [AW-1:0] a, input logic [7:0] v);
    @(negedge clk);
    req_addr  = a;
    req_priv  = v[7:6];
    req_virt  = v[5];
    req_men   = v[4];
    req_hen   = v[3];
    req_sen   = v[2];
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Walks one zeroing sequence from the current negedge, optional stall at index stall_at.
  task automatic run_zero(input logic [AW-1:0] base, input int stall_at, input string tag);
    int bad = 0;
    int bad_stall = 0;
    longint first_bad = 0;
    for (int j = 0; j < BLK; j++) begin
      if (j == stall_at) begin
        wr_ready = 1'b0;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          if (!wr_valid || wr_addr != base + AW'(j) || wr_data != 8'h00) bad_stall++;
        end
        wr_ready = 1'b1;
      end
      if (!wr_valid || wr_addr != base + AW'(j) || wr_data != 8'h00) begin
        if (bad == 0) first_bad = longint'(wr_addr);
        bad++;
      end
      @(negedge clk);
    end
    chk(bad == 0, {tag, " R6 ascending zero writes from aligned base"}, first_bad, longint'(base));
    if (stall_at >= 0)
      chk(bad_stall == 0, "R8 write held under back-pressure", bad_stall, 0);
    chk(done && !exc_valid && !wr_valid, {tag, " R7 done after last write"},
        {done, exc_valid, wr_valid}, 3'b100);
    @(negedge clk);
    chk(!done && req_ready, {tag, " R10 done lasts one cycle"}, {done, req_ready}, 2'b01);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !wr_valid && !done && !exc_valid, "R1 reset state",
        {req_ready, wr_valid, done, exc_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !wr_valid, "R1 idle after reset", {req_ready, wr_valid}, 2'b10);

    // Permission table
    for (int i = 0; i < 12; i++) begin
      logic [AW-1:0] a;
      logic [1:0]    k;
      a = 32'h1000_0000 + AW'(i) * 32'h0001_0457;
      k = VEC[i][1:0];
      do_req(a, VEC[i]);
      if (k == 2'd0) begin
        run_zero(a & MASK, -1, $sformatf("vec%0d", i));
      end else begin
        chk(exc_valid && exc_kind == k && !wr_valid && !done,
            $sformatf("vec%0d R2/R3/R4/R5 exception kind", i), exc_kind, k);
        chk(exc_addr == (a & MASK), $sformatf("vec%0d R10 aligned exc_addr", i),
            exc_addr, a & MASK);
        @(negedge clk);
        chk(!exc_valid && req_ready && !wr_valid, $sformatf("vec%0d R10 exc one cycle", i),
            {exc_valid, req_ready, wr_valid}, 3'b010);
      end
    end

    // R8: stalled from the first write, then a mid-block stall
    wr_ready = 1'b0;
    do_req(32'h0000_2FFF, VEC[0]);
    begin
      int bad = 0;
      for (int s = 0; s < 4; s++) begin
        if (!wr_valid || wr_addr != 32'h0000_2FC0) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R8 first write held while wr_ready low", bad, 0);
    end
    wr_ready = 1'b1;
    run_zero(32'h0000_2FC0, 10, "stall");

    // R9: store fault on the sixth write
    do_req(32'h0000_4123, VEC[0]);
    for (int j = 0; j < 5; j++) @(negedge clk);
    chk(wr_valid && wr_addr == 32'h0000_4105, "R8 address before fault", wr_addr, 32'h0000_4105);
    wr_fault = 1'b1;
    @(negedge clk);
    wr_fault = 1'b0;
    chk(exc_valid && exc_kind == 2'd3 && !wr_valid && !done, "R9 store fault reported",
        exc_kind, 2'd3);
    chk(exc_addr == 32'h0000_4100, "R9 fault carries aligned base", exc_addr, 32'h0000_4100);
    @(negedge clk);
    chk(!exc_valid && !wr_valid && req_ready, "R9 no writes after fault",
        {exc_valid, wr_valid, req_ready}, 3'b001);

    // R11: request offered while busy is ignored
    do_req(32'h0000_8040, VEC[0]);
    req_addr  = 32'h0000_9000;
    req_valid = 1'b1;
    begin
      int bad = 0;
      for (int j = 0; j < 10; j++) begin
        if (!wr_valid || wr_addr != 32'h0000_8040 + AW'(j)) bad++;
        @(negedge clk);
      end
      req_valid = 1'b0;
      for (int j = 10; j < BLK; j++) begin
        if (!wr_valid || wr_addr != 32'h0000_8040 + AW'(j)) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R11 busy request does not disturb sequence", bad, 0);
    end
    chk(done, "R11 sequence completes", done, 1);
    repeat (3) @(negedge clk);
    chk(!wr_valid && req_ready, "R11 ignored request starts nothing",
        {wr_valid, req_ready}, 2'b01);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule